// File: doc/BRIEF.md
# Prescaled Up/Down/Centre Timebase Counter

The block is a timebase for a larger timer. A programmable prescaler divides the reference clock. On each prescaler tick the main counter takes one step. It counts upward, downward, or up and then down (centre-aligned), and it turns around at a programmable reload limit. Each wrap or reversal raises a one-cycle update event. The counter then either keeps running or, in one-shot operation, stops itself.

A trigger output repeats either the update event or the moment the counter is started. The counter can be started through the configuration port or from an external start input. Prescaler and reload values written through the config port wait in preload registers. They move into the working copies at the next update event or at a start, so a write never cuts short a period already in progress.

Configuration uses a simple write-only parallel port: a write strobe, a 2-bit address and a data word.

- Address 0 is the control word:
  - bits [1:0] select the mode: 0 = up, 1 = down, 2 or 3 = up/down.
  - bit 2 selects one-shot operation.
  - bit 3 selects the trigger source: 0 = update event, 1 = start.
  - bit 4 is the enable.
- Address 1 is the prescaler value.
- Address 2 is the reload limit.

Top module: `tmr_timebase`

## Requirements
- R1: With prescaler value P in effect, the counter advances on exactly one reference cycle in every P+1 while running, the first step landing P+1 cycles after the start edge.
- R2: In up mode (mode 0) the counter steps 0,1,…,ARR. The step after ARR returns it to 0, and that return raises an update event.
- R3: In down mode (mode 1) the counter starts at ARR and steps down to 0. The step after 0 reloads ARR, and that reload raises an update event.
- R4: In up/down mode (mode 2 or 3) the counter starts at 0, rises to ARR, falls to 0 and repeats. An update event is raised at each reversal, so events are ARR ticks apart.
- R5: `uev_o` is a registered single-cycle pulse. It is high in the cycle that follows the wrapping tick, alongside the wrapped count, and it is only raised while the counter was running.
- R6: With control bit 2 set, the counter clears its enable at the wrap and then holds its wrapped value with no further events.
- R7: `trgo_o` pulses with each update event when control bit 3 is 0. When bit 3 is 1 it pulses only in the cycle after the counter is started.
- R8: A reload-limit write while running does not change the period in progress. The new limit applies from the next update event onward.
- R9: Writing control bit 4 = 0 freezes the counter and prescaler. A write with bit 4 = 1, or a high `ext_start`, while stopped restarts the prescaler at 0 and the counter at 0 (up, up/down) or at ARR (down). The cycle with the stopping write still counts as a running cycle.
- R10: With ARR = 0 the counter stays at 0 and every tick raises an update event, in all modes.
- R11: After reset the counter is 0, it is stopped, and `uev_o` and `trgo_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config register select (0 control, 1 prescaler, 2 reload) |
| cfg_wdata | input | 16 | Config write data |
| ext_start | input | 1 | External start request, acted on while stopped |
| cnt_o | output | 16 | Current counter value |
| uev_o | output | 1 | Update event pulse |
| trgo_o | output | 1 | Trigger output pulse |
| run_o | output | 1 | Counter enabled |

## Verification
The counting core is tried in all three modes with prescaler values 0, 1, 2 and 23. For each pattern the bench checks the final count and the number of update events. The final count separates the modes and catches off-by-one steps; the event count separates the up/down period of ARR ticks from the ARR+1 ticks of up and down mode. Reload limits of 0 put every mode into the tick-every-event corner. Directed sequences then cover one-shot stopping, freezing and restarting, a reload write that lands mid-period, and the two trigger sources, including a start from the external pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Counting modes (control bits [1:0]); code 3 behaves as up/down
  localparam logic [1:0] MODE_UP   = 2'd0;
  localparam logic [1:0] MODE_DOWN = 2'd1;
  localparam logic [1:0] MODE_CTR  = 2'd2;

  // Config port addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PSC  = 2'd1;
  localparam logic [1:0] ADDR_ARR  = 2'd2;

  // Control word bit positions
  localparam int CTRL_ONESHOT = 2;
  localparam int CTRL_TRGSEL  = 3;
  localparam int CTRL_EN      = 4;
endpackage

// File: rtl/tmr_cfg.sv
module tmr_cfg #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_sh,
  output logic              en_set,
  output logic              en_clr,
  output logic [1:0]        mode_q,
  output logic [1:0]        mode_nx,
  output logic              oneshot_q,
  output logic              trg_sel_q,
  output logic              trg_sel_nx,
  output logic [CNT_W-1:0]  arr_pre,
  output logic [CNT_W-1:0]  arr_sh,
  output logic [PSC_W-1:0]  psc_sh
);
  import tmr_pkg::*;

  logic             wr_ctrl;
  logic [PSC_W-1:0] psc_pre;

  assign wr_ctrl    = we && (addr == ADDR_CTRL);
  assign en_set     = wr_ctrl && wdata[CTRL_EN];
  assign en_clr     = wr_ctrl && !wdata[CTRL_EN];
  assign mode_nx    = wr_ctrl ? wdata[1:0] : mode_q;
  assign trg_sel_nx = wr_ctrl ? wdata[CTRL_TRGSEL] : trg_sel_q;

  // Control fields and preload registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_UP;
      oneshot_q <= 1'b0;
      trg_sel_q <= 1'b0;
      psc_pre   <= '0;
      arr_pre   <= '0;
    end else if (we) begin
      if (addr == ADDR_CTRL) begin
        mode_q    <= wdata[1:0];
        oneshot_q <= wdata[CTRL_ONESHOT];
        trg_sel_q <= wdata[CTRL_TRGSEL];
      end
      if (addr == ADDR_PSC) psc_pre <= wdata[PSC_W-1:0];
      if (addr == ADDR_ARR) arr_pre <= wdata[CNT_W-1:0];
    end
  end

  // Working copies, refreshed on update event or start
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_sh <= '0;
      arr_sh <= '0;
    end else if (load_sh) begin
      psc_sh <= psc_pre;
      arr_sh <= arr_pre;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + ONE;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       start_mode,
  input  logic [CNT_W-1:0] arr_sh,
  input  logic [CNT_W-1:0] arr_pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dir_dn;
  logic             dir_nx;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    dir_nx = dir_dn;
    wrap   = 1'b0;
    case (mode)
      MODE_UP: begin
        if (cnt >= arr_sh) begin
          cnt_nx = '0;
          wrap   = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end
      MODE_DOWN: begin
        if (cnt == '0) begin
          cnt_nx = arr_pre;
          wrap   = 1'b1;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      default: begin
        if (!dir_dn) begin
          if (cnt >= arr_sh) begin
            wrap   = 1'b1;
            dir_nx = 1'b1;
            cnt_nx = (cnt == '0) ? '0 : cnt - ONE;
          end else begin
            cnt_nx = cnt + ONE;
          end
        end else begin
          if (cnt == '0) begin
            wrap   = 1'b1;
            dir_nx = 1'b0;
            cnt_nx = (arr_pre == '0) ? '0 : ONE;
          end else begin
            cnt_nx = cnt - ONE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_dn <= 1'b0;
    end else if (start) begin
      cnt    <= (start_mode == MODE_DOWN) ? arr_pre : '0;
      dir_dn <= 1'b0;
    end else if (tick) begin
      cnt    <= cnt_nx;
      dir_dn <= dir_nx;
    end
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter  int CNT_W  = 16,
  parameter  int PSC_W  = 16,
  localparam int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ext_start,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              uev_o,
  output logic              trgo_o,
  output logic              run_o
);
  logic             en_set, en_clr;
  logic [1:0]       mode_q, mode_nx;
  logic             oneshot_q, trg_sel_q, trg_sel_nx;
  logic [CNT_W-1:0] arr_pre, arr_sh;
  logic [PSC_W-1:0] psc_sh;
  logic             run_q, start, tick, wrap, uev_evt, load_sh;

  assign start   = !run_q && !en_clr && (en_set || ext_start);
  assign uev_evt = tick && wrap;
  assign load_sh = start || uev_evt;

  tmr_cfg #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .load_sh    (load_sh),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .mode_q     (mode_q),
    .mode_nx    (mode_nx),
    .oneshot_q  (oneshot_q),
    .trg_sel_q  (trg_sel_q),
    .trg_sel_nx (trg_sel_nx),
    .arr_pre    (arr_pre),
    .arr_sh     (arr_sh),
    .psc_sh     (psc_sh)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .restart (start),
    .div     (psc_sh),
    .tick    (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tick       (tick),
    .mode       (mode_q),
    .start_mode (mode_nx),
    .arr_sh     (arr_sh),
    .arr_pre    (arr_pre),
    .cnt        (cnt_o),
    .wrap       (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      uev_o  <= 1'b0;
      trgo_o <= 1'b0;
    end else begin
      if (en_clr)                       run_q <= 1'b0;
      else if (start)                   run_q <= 1'b1;
      else if (uev_evt && oneshot_q)    run_q <= 1'b0;
      uev_o  <= uev_evt;
      trgo_o <= trg_sel_nx ? start : uev_evt;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_o,
  input logic             uev_o,
  input logic             trgo_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] arr_sh,
  input logic [1:0]       mode_q,
  input logic             oneshot_q,
  input logic             trg_sel_q
);
  import tmr_pkg::*;

  AST_UEV_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    uev_o |-> $past(run_o)); // R5
  AST_FREEZE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !$past(run_o)) |-> $stable(cnt_o)); // R9
  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (uev_o && $past(mode_q) == MODE_UP) |-> (cnt_o == '0)); // R2
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (uev_o && $past(mode_q) == MODE_DOWN) |-> (cnt_o == arr_sh)); // R3
  AST_TRGO_FROM_UEV: assert property (@(posedge clk) disable iff (rst)
    (trgo_o && !trg_sel_q) |-> uev_o); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (uev_o && $past(oneshot_q)) |-> !run_o); // R6
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_o     (run_o),
  .uev_o     (uev_o),
  .trgo_o    (trgo_o),
  .cnt_o     (cnt_o),
  .arr_sh    (arr_sh),
  .mode_q    (mode_q),
  .oneshot_q (oneshot_q),
  .trg_sel_q (trg_sel_q)
);

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        ext_start = 1'b0;
  logic [15:0] cnt_o;
  logic        uev_o, trgo_o, run_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tmr_timebase u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_start(ext_start), .cnt_o(cnt_o),
    .uev_o(uev_o), .trgo_o(trgo_o), .run_o(run_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      errors = errors + 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Control word: bits[1:0] mode, bit2 one-shot, bit3 trigger source, bit4 enable
  function automatic logic [15:0] ctrl(input logic [1:0] m, input logic os,
                                       input logic ts, input logic en);
    return {11'd0, en, ts, os, m};
  endfunction

  task automatic setup(input logic [1:0] m, input logic [15:0] p,
                       input logic [15:0] a, input logic os, input logic ts);
    cfg_write(2'd0, ctrl(m, 1'b0, 1'b0, 1'b0));
    cfg_write(2'd1, p);
    cfg_write(2'd2, a);
    cfg_write(2'd0, ctrl(m, os, ts, 1'b1));
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] ncyc;
    logic [15:0] exp_cnt;
    logic [15:0] exp_uev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd0,  16'd3, 16'd10,  16'd2, 16'd2},  // R2 up
    '{2'd0, 16'd1,  16'd3, 16'd17,  16'd0, 16'd2},  // R1 half rate
    '{2'd1, 16'd0,  16'd3, 16'd10,  16'd1, 16'd2},  // R3 down
    '{2'd1, 16'd2,  16'd5, 16'd20,  16'd5, 16'd1},  // R3/R1
    '{2'd2, 16'd0,  16'd3, 16'd10,  16'd2, 16'd3},  // R4 up/down
    '{2'd3, 16'd1,  16'd4, 16'd23,  16'd3, 16'd2},  // R4 code 3
    '{2'd0, 16'd23, 16'd2, 16'd100, 16'd1, 16'd1},  // R1 divide by 24
    '{2'd0, 16'd0,  16'd0, 16'd5,   16'd0, 16'd5},  // R10 up
    '{2'd1, 16'd1,  16'd0, 16'd6,   16'd0, 16'd3},  // R10 down
    '{2'd2, 16'd0,  16'd0, 16'd4,   16'd0, 16'd4}   // R10 up/down
  };

  initial begin
    int nuev;
    int ntrg;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 cnt", cnt_o, 0);
    chk("R11 run", run_o, 0);
    chk("R11 uev", uev_o, 0);
    chk("R11 trgo", trgo_o, 0);

    // Table of patterns (R1..R5, R7, R10)
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].mode, VECS[i].psc, VECS[i].arr, 1'b0, 1'b0);
      nuev = 0; ntrg = 0;
      for (int c = 0; c < int'(VECS[i].ncyc); c++) begin
        @(negedge clk);
        if (uev_o) nuev++;
        if (trgo_o) ntrg++;
      end
      chk($sformatf("R1/R2/R3/R4 vec%0d cnt", i), cnt_o, VECS[i].exp_cnt);
      chk($sformatf("R5 vec%0d uev count", i), nuev, VECS[i].exp_uev);
      chk($sformatf("R7 vec%0d trgo follows uev", i), ntrg, VECS[i].exp_uev);
    end

    // R6 one-shot: up, ARR=2
    setup(2'd0, 16'd0, 16'd2, 1'b1, 1'b0);
    nuev = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (uev_o) nuev++;
    end
    chk("R6 cnt after wrap", cnt_o, 0);
    chk("R6 run cleared", run_o, 0);
    chk("R6 one event", nuev, 1);
    nuev = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (uev_o) nuev++;
    end
    chk("R6 holds cnt", cnt_o, 0);
    chk("R6 no more events", nuev, 0);

    // R9 stop freezes, restart from 0
    setup(2'd0, 16'd0, 16'd9, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 running cnt", cnt_o, 4);
    cfg_write(2'd0, ctrl(2'd0, 1'b0, 1'b0, 1'b0));
    chk("R9 stop edge cnt", cnt_o, 5);
    chk("R9 stopped", run_o, 0);
    repeat (6) @(negedge clk);
    chk("R9 frozen cnt", cnt_o, 5);
    cfg_write(2'd0, ctrl(2'd0, 1'b0, 1'b0, 1'b1));
    chk("R9 restart cnt", cnt_o, 0);
    chk("R9 restart run", run_o, 1);

    // R8 reload write mid-period
    setup(2'd0, 16'd0, 16'd3, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    cfg_write(2'd2, 16'd1);
    chk("R8 period kept", cnt_o, 3);
    @(negedge clk);
    chk("R8 wrap cnt", cnt_o, 0);
    chk("R8 wrap uev", uev_o, 1);
    @(negedge clk);
    chk("R8 new limit step", cnt_o, 1);
    @(negedge clk);
    chk("R8 new limit wrap", cnt_o, 0);
    chk("R8 new limit uev", uev_o, 1);

    // R7 trigger on start
    setup(2'd0, 16'd0, 16'd1, 1'b0, 1'b1);
    chk("R7 trgo on start", trgo_o, 1);
    @(negedge clk);
    chk("R7 trgo one cycle", trgo_o, 0);
    @(negedge clk);
    chk("R7 uev present", uev_o, 1);
    chk("R7 trgo not on uev", trgo_o, 0);

    // R9 external start in down mode
    cfg_write(2'd0, ctrl(2'd1, 1'b0, 1'b1, 1'b0));
    cfg_write(2'd2, 16'd6);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    chk("R9 ext start run", run_o, 1);
    chk("R9 ext start down cnt", cnt_o, 6);
    chk("R7 ext start trgo", trgo_o, 1);
    @(negedge clk);
    chk("R3 down step", cnt_o, 5);
    chk("R7 trgo drops", trgo_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule